// File: doc/BRIEF.md
# Serial Programming Read Sequencer

This block is a host-side controller that reads a run of bytes out of a target device's code memory over a two-wire programming link. The link has a host-driven clock and one bidirectional data line. The host drives the line through a separate output enable and reads it back through an input pin. A request carries a 22-bit start address and a byte count. The sequencer first steers the target's three-byte table pointer to that address by executing core instructions on the target. It then issues a table-read-with-post-increment transfer once per byte. Each returned byte goes out on a valid/ready stream.

Every transfer on the link is a 4-bit command followed by a 16-bit operand, both least significant bit first. In a read transfer, the first operand byte is filler. Before the second byte, the host releases the line and holds the clock low for a timed turnaround. The target then shifts its byte back. The clock half-period and the turnaround length are parameters counted in system clocks.

Top module: `pgm_read_seq`

## Requirements
- R1: After reset, start_ready is 1 and out_valid, pclk_o and pdat_oe are 0.
- R2: Each transfer sends a 4-bit command and then a 16-bit operand, both LSB first. The host changes pdat_o on the rising pclk_o edge, and the target samples on the falling edge. Every clock high phase lasts HALF_CLKS system clocks.
- R3: A request with a nonzero count starts with exactly six transfers with command 0000 (execute core instruction). Their operand words, in this order, are 0x0E00|addr[21:16], 0x6EF8, 0x0E00|addr[15:8], 0x6EF7, 0x0E00|addr[7:0] and 0x6EF6.
- R4: After the pointer load, exactly one transfer with command 1001 (table read, post-increment) is issued per requested byte. Its first operand byte is driven as zeros, and the pointer is not loaded again.
- R5: In a read transfer, pdat_oe falls at the falling pclk_o edge of the 8th operand bit. The clock then stays low for exactly TURN_CLKS system clocks. The host then samples 8 target bits on the next 8 falling edges, LSB first, while pdat_oe stays 0.
- R6: pdat_oe rises only together with the rising pclk_o edge that starts a new transfer.
- R7: Bytes appear on out_data in ascending address order, one per handshake. out_last is 1 exactly with the final byte of a request. out_valid and out_data hold while out_ready is 0.
- R8: While a delivered byte waits unconsumed, no transfer runs and pclk_o stays low.
- R9: start_ready is 1 only while no request is in progress. A request with count 0 is accepted and produces no byte and no clock activity.
- R10: Any start address up to 0x3FFFFF is read correctly, including the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Sequencer idle, request accepted when both high |
| start_addr | input | 22 | First code-memory address to read |
| start_count | input | CNT_W | Number of bytes to read |
| out_valid | output | 1 | Returned byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Returned byte |
| out_last | output | 1 | Final byte of the request |
| pclk_o | output | 1 | Programming link clock |
| pdat_o | output | 1 | Host data toward the target |
| pdat_oe | output | 1 | Host drives the data line when 1 |
| pdat_i | input | 1 | Data line as seen by the host |

## Verification
The assertions check several timing rules on every cycle: the release of the data line only at a falling clock and its return only at a rising one, the exact turnaround length, the clock held low while a byte waits, the stability of a stalled byte, and start_ready dropping once work is accepted. Other behaviour only shows through the bench's scenarios, because it needs a model of the target. That covers the command and instruction encodings, the pointer-load order, the per-byte read count, the byte values and order, the last flag, the top-of-range address and the zero-count request. The bench's target model decodes each transfer bit by bit and answers from its own computed memory image.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int CMD_W     = 4;
  localparam int OPND_W    = 16;
  localparam int XFER_BITS = CMD_W + OPND_W;
  localparam int ADDR_W    = 22;
  localparam int BYTE_W    = 8;
  localparam int LOAD_STEPS = 6;

  localparam logic [CMD_W-1:0] CMD_CORE    = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_TRD_INC = 4'b1001;

  localparam logic [7:0] OP_LIT_TO_W = 8'h0E;
  localparam logic [7:0] OP_W_TO_REG = 8'h6E;
  localparam logic [7:0] REG_PTR_HI  = 8'hF8;
  localparam logic [7:0] REG_PTR_MID = 8'hF7;
  localparam logic [7:0] REG_PTR_LO  = 8'hF6;

  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW, PH_TURN} phase_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_READ} seq_t;
endpackage

// File: rtl/pgm_ptr_words.sv
module pgm_ptr_words
  import pgm_pkg::*;
(
  input  logic [2:0]          step,
  input  logic [ADDR_W-1:0]   addr,
  output logic [OPND_W-1:0]   word
);
  // Literal-then-store pairs walk the pointer from upper to lower byte.
  always_comb begin
    unique case (step)
      3'd0:    word = {OP_LIT_TO_W, 2'b00, addr[21:16]};
      3'd1:    word = {OP_W_TO_REG, REG_PTR_HI};
      3'd2:    word = {OP_LIT_TO_W, addr[15:8]};
      3'd3:    word = {OP_W_TO_REG, REG_PTR_MID};
      3'd4:    word = {OP_LIT_TO_W, addr[7:0]};
      default: word = {OP_W_TO_REG, REG_PTR_LO};
    endcase
  end
endmodule

// File: rtl/pgm_xfer_engine.sv
module pgm_xfer_engine
  import pgm_pkg::*;
#(
  parameter int HALF_CLKS = 2,
  parameter int TURN_CLKS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [CMD_W-1:0]    go_cmd,
  input  logic [OPND_W-1:0]   go_opnd,
  input  logic                go_read,
  output logic                busy,
  output logic                done,
  output logic [BYTE_W-1:0]   rd_byte,
  output logic                pclk_o,
  output logic                pdat_o,
  output logic                pdat_oe,
  input  logic                pdat_i
);
  localparam int TMR_MAX = (HALF_CLKS > TURN_CLKS) ? HALF_CLKS : TURN_CLKS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BIT_W   = $clog2(XFER_BITS);
  localparam logic [TMR_W-1:0] HALF_LD  = TMR_W'(HALF_CLKS - 1);
  localparam logic [TMR_W-1:0] TURN_LD  = TMR_W'(TURN_CLKS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(XFER_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_OUT = BIT_W'(CMD_W + BYTE_W - 1);

  phase_t                 ph;
  logic [TMR_W-1:0]       tmr;
  logic [BIT_W-1:0]       bit_idx;
  logic [XFER_BITS-1:0]   sh;
  logic                   rd_mode;
  logic [BYTE_W-1:0]      cap;

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      ph      <= PH_IDLE;
      tmr     <= '0;
      bit_idx <= '0;
      sh      <= '0;
      rd_mode <= 1'b0;
      cap     <= '0;
      rd_byte <= '0;
      pclk_o  <= 1'b0;
      pdat_o  <= 1'b0;
      pdat_oe <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (go) begin
            sh      <= {go_opnd, go_cmd};
            pdat_o  <= go_cmd[0];
            pdat_oe <= 1'b1;
            pclk_o  <= 1'b1;
            bit_idx <= '0;
            rd_mode <= go_read;
            tmr     <= HALF_LD;
            ph      <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tmr == '0) begin
            pclk_o <= 1'b0;
            if (rd_mode && (bit_idx > LAST_OUT))
              cap <= {pdat_i, cap[BYTE_W-1:1]};
            if (rd_mode && (bit_idx == LAST_OUT)) begin
              pdat_oe <= 1'b0;
              tmr     <= TURN_LD;
              ph      <= PH_TURN;
            end else begin
              tmr <= HALF_LD;
              ph  <= PH_LOW;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: begin
          if (tmr == '0) begin
            if (bit_idx == LAST_BIT) begin
              ph   <= PH_IDLE;
              done <= 1'b1;
              if (rd_mode) rd_byte <= cap;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              sh      <= sh >> 1;
              pdat_o  <= sh[1];
              pclk_o  <= 1'b1;
              tmr     <= HALF_LD;
              ph      <= PH_HIGH;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pgm_out_slot.sv
module pgm_out_slot #(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  input  logic          load_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pgm_read_seq.sv
module pgm_read_seq
  import pgm_pkg::*;
#(
  parameter int HALF_CLKS = 2,
  parameter int TURN_CLKS = 5,
  parameter int CNT_W     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic [21:0]         start_addr,
  input  logic [CNT_W-1:0]    start_count,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [7:0]          out_data,
  output logic                out_last,
  output logic                pclk_o,
  output logic                pdat_o,
  output logic                pdat_oe,
  input  logic                pdat_i
);
  localparam logic [2:0]       LAST_STEP = 3'(LOAD_STEPS - 1);
  localparam logic [CNT_W-1:0] ONE_LEFT  = CNT_W'(1);

  seq_t               st;
  logic [2:0]         step;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   left;
  logic               waiting;
  logic               go;
  logic               eng_busy;
  logic               eng_done;
  logic [BYTE_W-1:0]  eng_byte;
  logic [OPND_W-1:0]  ptr_word;
  logic [CMD_W-1:0]   go_cmd;
  logic [OPND_W-1:0]  go_opnd;
  logic               go_read;
  logic               slot_load;

  assign start_ready = (st == SQ_IDLE);
  assign go = !waiting && !eng_busy &&
              ((st == SQ_LOAD) ||
               ((st == SQ_READ) && (left != '0) && !out_valid));
  assign go_read   = (st == SQ_READ);
  assign go_cmd    = go_read ? CMD_TRD_INC : CMD_CORE;
  assign go_opnd   = go_read ? '0 : ptr_word;
  assign slot_load = eng_done && (st == SQ_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      step    <= '0;
      addr_q  <= '0;
      left    <= '0;
      waiting <= 1'b0;
    end else begin
      if (go) waiting <= 1'b1;
      else if (eng_done) waiting <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (start_valid && (start_count != '0)) begin
            addr_q <= start_addr;
            left   <= start_count;
            step   <= '0;
            st     <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          if (eng_done) begin
            step <= step + 1'b1;
            if (step == LAST_STEP) st <= SQ_READ;
          end
        end
        default: begin
          if (eng_done) left <= left - 1'b1;
          else if ((left == '0) && !out_valid && !waiting) st <= SQ_IDLE;
        end
      endcase
    end
  end

  pgm_ptr_words u_words (
    .step (step),
    .addr (addr_q),
    .word (ptr_word)
  );

  pgm_xfer_engine #(
    .HALF_CLKS (HALF_CLKS),
    .TURN_CLKS (TURN_CLKS)
  ) u_eng (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .go_cmd  (go_cmd),
    .go_opnd (go_opnd),
    .go_read (go_read),
    .busy    (eng_busy),
    .done    (eng_done),
    .rd_byte (eng_byte),
    .pclk_o  (pclk_o),
    .pdat_o  (pdat_o),
    .pdat_oe (pdat_oe),
    .pdat_i  (pdat_i)
  );

  pgm_out_slot #(.W(BYTE_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (slot_load),
    .load_data (eng_byte),
    .load_last (left == ONE_LEFT),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );
endmodule

// File: rtl/pgm_read_seq_chk.sv
module pgm_read_seq_chk #(
  parameter int TURN_CLKS = 5,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_valid,
  input logic             start_ready,
  input logic [CNT_W-1:0] start_count,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             pclk_o,
  input logic             pdat_oe
);
  logic [15:0] low_run;
  logic        prev_oe;
  logic        turn_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run   <= '0;
      prev_oe   <= 1'b0;
      turn_pend <= 1'b0;
    end else begin
      low_run <= pclk_o ? 16'd0 : low_run + 16'd1;
      prev_oe <= pdat_oe;
      if (prev_oe && !pdat_oe) turn_pend <= 1'b1;
      else if (pclk_o) turn_pend <= 1'b0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (start_ready && !out_valid && !pclk_o && !pdat_oe));

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pdat_oe) |-> $fell(pclk_o));

  // R5
  turn_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pclk_o) && turn_pend) |-> (low_run == 16'(TURN_CLKS)));

  // R6
  oe_resume_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pdat_oe) |-> $rose(pclk_o));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  pause_low_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !pclk_o);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (start_valid && start_ready && (start_count != '0)) |=> !start_ready);
endmodule

bind pgm_read_seq pgm_read_seq_chk #(
  .TURN_CLKS (TURN_CLKS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .start_count (start_count),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .pclk_o      (pclk_o),
  .pdat_oe     (pdat_oe)
);

// File: tb/pgm_read_seq_bench.sv
module pgm_read_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF = 2;
  localparam int TURN = 5;
  localparam int CW   = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [21:0]   start_addr = '0;
  logic [CW-1:0] start_count = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;
  logic          out_last;
  logic          pclk_o, pdat_o, pdat_oe;
  logic          tgt_en = 1'b0;
  logic          tgt_bit = 1'b0;
  logic          pdat_i;

  assign pdat_i = tgt_en ? tgt_bit : 1'b1;

  always #2.5 clk = ~clk;

  pgm_read_seq #(.HALF_CLKS(HALF), .TURN_CLKS(TURN), .CNT_W(CW)) u_pgm_read_seq (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .start_addr(start_addr), .start_count(start_count), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .pclk_o(pclk_o), .pdat_o(pdat_o), .pdat_oe(pdat_oe), .pdat_i(pdat_i));

  int total = 0;
  int bad = 0;
  int n_core = 0;
  int n_read = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;
  logic [8:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [21:0] a);
    return (a[7:0] ^ a[15:8] ^ {a[21:16], 2'b01}) + 8'h37;
  endfunction

  // Target model: decodes transfers and answers table reads.
  initial begin
    logic [19:0] sh = '0;
    logic [3:0]  cmd = '0;
    logic [7:0]  wreg = '0;
    logic [21:0] ptr = '0;
    logic [7:0]  latch = '0;
    int          bitcnt = 0;
    bit          turn_pend = 1'b0;
    bit          host_bit, oe_h;
    realtime     t_rise, t_fall = 0;
    forever begin
      @(posedge pclk_o);
      t_rise = $realtime;
      if (cmd == 4'b1001 && bitcnt >= 12) begin
        tgt_en  = 1'b1;
        tgt_bit = latch[bitcnt-12];
      end
      #1;
      host_bit = pdat_o;
      oe_h     = pdat_oe;
      if (bitcnt == 0) chk(oe_h == 1'b1, "R6 drive at command start", oe_h, 1);
      if (turn_pend) begin
        chk(int'((t_rise - t_fall) / 5.0) == TURN, "R5 turnaround",
            int'((t_rise - t_fall) / 5.0), TURN);
        chk(oe_h == 1'b0, "R5 line released", oe_h, 0);
        turn_pend = 1'b0;
      end
      @(negedge pclk_o);
      chk(int'(($realtime - t_rise) / 5.0) == HALF, "R2 high phase",
          int'(($realtime - t_rise) / 5.0), HALF);
      sh = {host_bit, sh[19:1]};
      bitcnt++;
      if (bitcnt == 4) cmd = sh[19:16];
      if (bitcnt == 12 && cmd == 4'b1001) begin
        chk(sh[19:12] == 8'h00, "R4 dummy operand", sh[19:12], 0);
        latch = mem(ptr);
        ptr = ptr + 22'd1;
        n_read++;
        t_fall = $realtime;
        turn_pend = 1'b1;
      end
      if (bitcnt == 20) begin
        bitcnt = 0;
        if (cmd == 4'b0000) begin
          n_core++;
          if (sh[19:12] == 8'h0E) wreg = sh[11:4];
          else if (sh[19:12] == 8'h6E) begin
            case (sh[11:4])
              8'hF8:   ptr[21:16] = wreg[5:0];
              8'hF7:   ptr[15:8]  = wreg;
              8'hF6:   ptr[7:0]   = wreg;
              default: chk(1'b0, "R3 store target", sh[11:4], 8'hF6);
            endcase
          end else chk(1'b0, "R3 instruction", sh[19:4], 16'h0E00);
        end else if (cmd == 4'b1001) begin
          tgt_en = 1'b0;
        end else chk(1'b0, "R2 command code", cmd, 0);
        cmd = '0;
      end
    end
  end

  // Consumer and scoreboard monitor.
  initial begin
    int ctr = 0;
    logic [8:0] e;
    forever begin
      @(negedge clk);
      ctr++;
      out_ready = stall_mode ? ((ctr % 4) == 3) : 1'b1;
      if (out_valid === 1'b1 && !out_ready)
        chk(pclk_o == 1'b0, "R8 clock low while stalled", pclk_o, 0);
      if (out_valid === 1'b1 && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R7 unexpected byte", out_data, 0);
        else begin
          e = expq.pop_front();
          chk(out_data == e[7:0], "R7 byte value", out_data, e[7:0]);
          chk(out_last == e[8], "R7 last flag", out_last, e[8]);
        end
      end
    end
  end

  task automatic issue(input logic [21:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) expq.push_back({(i == n - 1), mem(a + 22'(i))});
    n_core = 0;
    n_read = 0;
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1;
    start_addr  = a;
    start_count = CW'(n);
    @(negedge clk);
    start_valid = 1'b0;
    if (n > 0) chk(start_ready == 1'b0, "R9 busy after accept", start_ready, 0);
    while (!(expq.size() == 0 && start_ready)) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_core == ((n > 0) ? 6 : 0), {"R3 pointer load ", tag}, n_core, (n > 0) ? 6 : 0);
    chk(n_read == n, {"R4 reads per byte ", tag}, n_read, n);
    chk(start_ready == 1'b1, {"R9 idle after ", tag}, start_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(start_ready == 1'b1, "R1 start_ready", start_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(pclk_o == 1'b0, "R1 pclk", pclk_o, 0);
    chk(pdat_oe == 1'b0, "R1 enable", pdat_oe, 0);
    rst = 1'b0;
    issue(22'h000010, 4, "low run");
    issue(22'h3FFFFE, 2, "R10 top of space");
    stall_mode = 1'b1;
    issue(22'h12AB5C, 5, "stalled consumer");
    stall_mode = 1'b0;
    issue(22'h2C0031, 0, "R9 zero count");
    issue(22'h0000FF, 1, "single byte");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule